// File: doc/BRIEF.md
# ISA Bus Dual-Window Address Decoder

This block tells a peripheral when an ISA bus cycle belongs to it. It watches the 20-bit system address, the four active-low bus strobes and an active-low chip select. It raises one of four select lines: I/O read, I/O write, memory read or memory write. Two independent decode windows are checked in parallel.

The I/O window has 16-byte granularity and is always active. Its base register comes out of reset pointing at 0x0300. The memory window has 4 KB granularity. It claims a cycle only while the memory-enable bit is set and the chip select is low.

A small synchronous configuration port relocates both windows and sets the enable bit. The port has a write strobe, a register offset and a 16-bit data word. The block carries no data stream, so every pin is a plain level with no valid/ready handshake. The select outputs are combinational from the bus pins and the stored bases, so a claim appears within the same bus cycle.

Top module: `isa_dual_window_decoder`

## Requirements
- R1: After reset the I/O base holds 0x0300, the memory base holds 0 and memory decoding is disabled, so an I/O read at 0x300 is claimed and no memory strobe is claimed.
- R2: The I/O window compares only address bits [15:4] with the I/O base; address bits [3:0] and [19:16] have no effect on an I/O claim.
- R3: `io_rd_sel` is high only when the I/O window matches and `ior_n` is low; `io_wr_sel` is high only when it matches and `iow_n` is low; with neither strobe low nothing is claimed.
- R4: `chipsel_n` has no effect on I/O claims.
- R5: A configuration write at offset 0x020 loads the 16-bit I/O base, which takes effect from the next clock edge onward; without a write the base holds.
- R6: A memory claim requires memory decoding enabled, `chipsel_n` low, address bits [19:12] equal to memory base bits [19:12], and `memr_n` low (read) or `memw_n` low (write); address bits [11:0] have no effect.
- R7: When both the read and the write strobe of one space are low together, neither select of that space is raised.
- R8: A write at offset 0x02C loads memory base bits [15:0] from the data word; a write at offset 0x02E loads memory base bits [19:16] from data bits [3:0] and ignores data bits [15:4].
- R9: A write at offset 0x116 loads the memory-enable bit from data bit 10, and the other data bits of that write have no effect; memory decoding is disabled while the bit is 0.
- R10: The I/O window stays live while memory decoding is enabled, and a single bus state can raise an I/O select and a memory select together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe, sampled at the rising edge |
| cfg_off | input | 10 | Register offset of the configuration write |
| cfg_wdata | input | 16 | Configuration write data |
| sa | input | 20 | ISA system address |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| memr_n | input | 1 | Memory read strobe, active low |
| memw_n | input | 1 | Memory write strobe, active low |
| chipsel_n | input | 1 | Chip select for memory cycles, active low |
| io_rd_sel | output | 1 | I/O read cycle claimed |
| io_wr_sel | output | 1 | I/O write cycle claimed |
| mem_rd_sel | output | 1 | Memory read cycle claimed |
| mem_wr_sel | output | 1 | Memory write cycle claimed |

## Verification
The assertions assume that the bus pins and the configuration port carry known values from the first clock after reset. They also assume that `cfg_off` and `cfg_wdata` are settled whenever `cfg_we` is high at an edge. The bench meets both by driving every input to its idle level before reset is released. It changes stimulus only one time unit after a rising edge and samples at the falling edge. While it performs a configuration write, it keeps all four strobes idle, so no bus cycle overlaps a base update.

// File: rtl/isa_dec_pkg.sv
package isa_dec_pkg;
  localparam int SA_W   = 20;
  localparam int IO_W   = 16;
  localparam int DATA_W = 16;
  localparam int OFF_W  = 10;

  localparam int IO_IGN  = 4;
  localparam int MEM_IGN = 12;

  localparam int MEMEN_BIT = 10;

  localparam logic [OFF_W-1:0] OFF_IO_BASE = 10'h020;
  localparam logic [OFF_W-1:0] OFF_MEM_LO  = 10'h02C;
  localparam logic [OFF_W-1:0] OFF_MEM_HI  = 10'h02E;
  localparam logic [OFF_W-1:0] OFF_BUS_CTL = 10'h116;

  localparam logic [IO_W-1:0] IO_RESET_BASE = 16'h0300;

  localparam int SP_IO  = 0;
  localparam int SP_MEM = 1;
  localparam int N_SPACE = 2;
endpackage

// File: rtl/isa_cfg_regs.sv
module isa_cfg_regs
  import isa_dec_pkg::*;
#(
  parameter int              SA_WIDTH   = SA_W,
  parameter int              IO_WIDTH   = IO_W,
  parameter int              DATA_WIDTH = DATA_W,
  parameter logic [IO_W-1:0] IO_INIT    = IO_RESET_BASE
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [OFF_W-1:0]      off,
  input  logic [DATA_WIDTH-1:0] wdata,
  output logic [IO_WIDTH-1:0]   io_base,
  output logic [SA_WIDTH-1:0]   mem_base,
  output logic                  mem_en
);
  localparam int HI_W = SA_WIDTH - DATA_WIDTH;

  logic [IO_WIDTH-1:0] io_base_q;
  logic [SA_WIDTH-1:0] mem_base_q;
  logic                mem_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_base_q  <= IO_INIT;
      mem_base_q <= '0;
      mem_en_q   <= 1'b0;
    end else if (we) begin
      case (off)
        OFF_IO_BASE: io_base_q <= wdata[IO_WIDTH-1:0];
        OFF_MEM_LO:  mem_base_q[DATA_WIDTH-1:0] <= wdata;
        OFF_MEM_HI:  mem_base_q[SA_WIDTH-1:DATA_WIDTH] <= wdata[HI_W-1:0];
        OFF_BUS_CTL: mem_en_q <= wdata[MEMEN_BIT];
        default: ;
      endcase
    end
  end

  assign io_base  = io_base_q;
  assign mem_base = mem_base_q;
  assign mem_en   = mem_en_q;

  // R5: the I/O base holds unless it is written
  p_io_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && off == OFF_IO_BASE) |=> $stable(io_base_q));

  // R5: an I/O base write lands at the next edge
  p_io_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && off == OFF_IO_BASE) |=> io_base_q == $past(wdata[IO_WIDTH-1:0]));

  // R8: the high half keeps only the low data nibble, the low half is untouched
  p_hi_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && off == OFF_MEM_HI) |=>
      (mem_base_q[SA_WIDTH-1:DATA_WIDTH] == $past(wdata[HI_W-1:0]) &&
       mem_base_q[DATA_WIDTH-1:0] == $past(mem_base_q[DATA_WIDTH-1:0])));

  // R9: enable only moves on a bus-control write
  p_en_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && off == OFF_BUS_CTL) |=> $stable(mem_en_q));
endmodule

// File: rtl/isa_window_match.sv
module isa_window_match #(
  parameter int CMP_W = 16,
  parameter int IGN_W = 4
) (
  input  logic [CMP_W-1:0] addr,
  input  logic [CMP_W-1:0] base,
  output logic             hit
);
  localparam logic [CMP_W-1:0] CARE = {{(CMP_W-IGN_W){1'b1}}, {IGN_W{1'b0}}};

  assign hit = ((addr ^ base) & CARE) == '0;
endmodule

// File: rtl/isa_strobe_qual.sv
module isa_strobe_qual (
  input  logic match,
  input  logic gate,
  input  logic rd_n,
  input  logic wr_n,
  output logic rd_sel,
  output logic wr_sel
);
  logic live;

  assign live   = match && gate;
  assign rd_sel = live && !rd_n && wr_n;
  assign wr_sel = live && !wr_n && rd_n;
endmodule

// File: rtl/isa_dual_window_decoder.sv
module isa_dual_window_decoder
  import isa_dec_pkg::*;
#(
  parameter int              SA_WIDTH   = SA_W,
  parameter int              IO_WIDTH   = IO_W,
  parameter int              DATA_WIDTH = DATA_W,
  parameter int              IO_GRAN    = IO_IGN,
  parameter int              MEM_GRAN   = MEM_IGN,
  parameter logic [IO_W-1:0] IO_INIT    = IO_RESET_BASE
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [OFF_W-1:0]      cfg_off,
  input  logic [DATA_WIDTH-1:0] cfg_wdata,
  input  logic [SA_WIDTH-1:0]   sa,
  input  logic                  ior_n,
  input  logic                  iow_n,
  input  logic                  memr_n,
  input  logic                  memw_n,
  input  logic                  chipsel_n,
  output logic                  io_rd_sel,
  output logic                  io_wr_sel,
  output logic                  mem_rd_sel,
  output logic                  mem_wr_sel
);
  logic [IO_WIDTH-1:0] io_base;
  logic [SA_WIDTH-1:0] mem_base;
  logic                mem_en;

  logic [N_SPACE-1:0] win_hit;
  logic [N_SPACE-1:0] win_gate;
  logic [N_SPACE-1:0] rd_n_v;
  logic [N_SPACE-1:0] wr_n_v;
  logic [N_SPACE-1:0] rd_sel_v;
  logic [N_SPACE-1:0] wr_sel_v;

  isa_cfg_regs #(
    .SA_WIDTH  (SA_WIDTH),
    .IO_WIDTH  (IO_WIDTH),
    .DATA_WIDTH(DATA_WIDTH),
    .IO_INIT   (IO_INIT)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .off     (cfg_off),
    .wdata   (cfg_wdata),
    .io_base (io_base),
    .mem_base(mem_base),
    .mem_en  (mem_en)
  );

  isa_window_match #(.CMP_W(IO_WIDTH), .IGN_W(IO_GRAN)) u_io_win (
    .addr(sa[IO_WIDTH-1:0]),
    .base(io_base),
    .hit (win_hit[SP_IO])
  );

  isa_window_match #(.CMP_W(SA_WIDTH), .IGN_W(MEM_GRAN)) u_mem_win (
    .addr(sa),
    .base(mem_base),
    .hit (win_hit[SP_MEM])
  );

  assign win_gate[SP_IO]  = 1'b1;
  assign win_gate[SP_MEM] = mem_en && !chipsel_n;
  assign rd_n_v[SP_IO]    = ior_n;
  assign wr_n_v[SP_IO]    = iow_n;
  assign rd_n_v[SP_MEM]   = memr_n;
  assign wr_n_v[SP_MEM]   = memw_n;

  for (genvar s = 0; s < N_SPACE; s++) begin : g_space
    isa_strobe_qual u_qual (
      .match (win_hit[s]),
      .gate  (win_gate[s]),
      .rd_n  (rd_n_v[s]),
      .wr_n  (wr_n_v[s]),
      .rd_sel(rd_sel_v[s]),
      .wr_sel(wr_sel_v[s])
    );
  end

  assign io_rd_sel  = rd_sel_v[SP_IO];
  assign io_wr_sel  = wr_sel_v[SP_IO];
  assign mem_rd_sel = rd_sel_v[SP_MEM];
  assign mem_wr_sel = wr_sel_v[SP_MEM];

  // R7: never both directions in one space
  p_io_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd_sel && io_wr_sel));
  p_mem_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_sel && mem_wr_sel));

  // R3: an I/O select always has its own strobe behind it
  p_io_rd_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd_sel |-> !ior_n);
  p_io_wr_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr_sel |-> !iow_n);

  // R2: an I/O claim sits inside the 16-byte block of the base
  p_io_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd_sel || io_wr_sel) |-> (sa[IO_WIDTH-1:IO_GRAN] == io_base[IO_WIDTH-1:IO_GRAN]));

  // R6: a memory claim needs chip select and an address inside the 4 KB page
  p_mem_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_sel || mem_wr_sel) |-> (!chipsel_n &&
      sa[SA_WIDTH-1:MEM_GRAN] == mem_base[SA_WIDTH-1:MEM_GRAN]));

  // R9: no memory claim while decoding is disabled
  p_mem_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_sel || mem_wr_sel) |-> mem_en);
endmodule

// File: tb/tb_isa_dual_window_decoder.sv
`timescale 1ns/1ps
module tb_isa_dual_window_decoder;
  typedef struct {
    logic [3:0] exp;   // {io_rd, io_wr, mem_rd, mem_wr}
    string      req;
  } sb_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [9:0]  cfg_off = '0;
  logic [15:0] cfg_wdata = '0;
  logic [19:0] sa = '0;
  logic        ior_n = 1'b1, iow_n = 1'b1, memr_n = 1'b1, memw_n = 1'b1;
  logic        chipsel_n = 1'b1;
  logic        io_rd_sel, io_wr_sel, mem_rd_sel, mem_wr_sel;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  sb_item_t sb[$];

  logic [15:0] m_io;
  logic [19:0] m_mem;
  logic        m_en;

  always #2 clk = ~clk;

  isa_dual_window_decoder dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_off(cfg_off),
    .cfg_wdata(cfg_wdata), .sa(sa), .ior_n(ior_n), .iow_n(iow_n),
    .memr_n(memr_n), .memw_n(memw_n), .chipsel_n(chipsel_n),
    .io_rd_sel(io_rd_sel), .io_wr_sel(io_wr_sel),
    .mem_rd_sel(mem_rd_sel), .mem_wr_sel(mem_wr_sel)
  );

  function automatic logic [3:0] model(input logic [19:0] a, input logic ir, iw,
                                       input logic mr, mw, cs);
    logic ioh, memh;
    ioh  = (a[15:4] == m_io[15:4]);
    memh = (a[19:12] == m_mem[19:12]) && m_en && !cs;
    return {ioh && !ir && iw, ioh && !iw && ir, memh && !mr && mw, memh && !mw && mr};
  endfunction

  task automatic cfg_write(input logic [9:0] off, input logic [15:0] d);
    @(posedge clk); #1;
    ior_n = 1; iow_n = 1; memr_n = 1; memw_n = 1;
    cfg_we = 1; cfg_off = off; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
    case (off)
      10'h020: m_io = d;
      10'h02C: m_mem[15:0] = d;
      10'h02E: m_mem[19:16] = d[3:0];
      10'h116: m_en = d[10];
      default: ;
    endcase
  endtask

  // drive one bus state and push the expected selects
  task automatic bus(input logic [19:0] a, input logic ir, iw, mr, mw, cs,
                     input string req);
    sb_item_t it;
    @(posedge clk); #1;
    sa = a; ior_n = ir; iow_n = iw; memr_n = mr; memw_n = mw; chipsel_n = cs;
    it.exp = model(a, ir, iw, mr, mw, cs);
    it.req = req;
    sb.push_back(it);
  endtask

  task automatic bus_fixed(input logic [19:0] a, input logic ir, iw, mr, mw, cs,
                           input logic [3:0] e, input string req);
    sb_item_t it;
    @(posedge clk); #1;
    sa = a; ior_n = ir; iow_n = iw; memr_n = mr; memw_n = mw; chipsel_n = cs;
    it.exp = e;
    it.req = req;
    sb.push_back(it);
  endtask

  // monitor
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      sb_item_t it;
      logic [3:0] act;
      it = sb.pop_front();
      act = {io_rd_sel, io_wr_sel, mem_rd_sel, mem_wr_sel};
      compared++;
      if (act !== it.exp) begin
        mismatched++;
        $display("FAIL %s: selects actual %b expected %b (sa=%h)", it.req, act, it.exp, sa);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    m_io = 16'h0300; m_mem = '0; m_en = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset defaults, fixed expectations
    bus_fixed(20'h00300, 0, 1, 1, 1, 1, 4'b1000, "R1 io base 0x300");
    bus_fixed(20'h00000, 1, 1, 0, 1, 0, 4'b0000, "R1 memory disabled");
    bus_fixed(20'h00000, 1, 1, 1, 0, 0, 4'b0000, "R1 memory disabled wr");

    // R2: aliasing across low nibble and top nibble
    bus(20'h0030F, 0, 1, 1, 1, 1, "R2 low nibble ignored");
    bus(20'h00305, 1, 0, 1, 1, 1, "R2 low nibble ignored wr");
    bus(20'hF0300, 0, 1, 1, 1, 1, "R2 bits 19:16 ignored");
    bus_fixed(20'h00310, 0, 1, 1, 1, 1, 4'b0000, "R2 next block misses");
    bus_fixed(20'h002FF, 0, 1, 1, 1, 1, 4'b0000, "R2 previous block misses");

    // R3 / R7: strobes
    bus_fixed(20'h00300, 1, 1, 1, 1, 1, 4'b0000, "R3 no strobe");
    bus_fixed(20'h00300, 1, 0, 1, 1, 1, 4'b0100, "R3 io write");
    bus_fixed(20'h00300, 0, 0, 1, 1, 1, 4'b0000, "R7 both io strobes");

    // R4: chip select ignored for I/O
    bus_fixed(20'h00300, 0, 1, 1, 1, 0, 4'b1000, "R4 cs low");
    bus_fixed(20'h00300, 0, 1, 1, 1, 1, 4'b1000, "R4 cs high");

    // R5: relocate I/O base
    cfg_write(10'h020, 16'h0ABC);
    bus(20'h00AB0, 0, 1, 1, 1, 1, "R5 new base");
    bus(20'h00ABF, 1, 0, 1, 1, 1, "R5 new base top");
    bus_fixed(20'h00300, 0, 1, 1, 1, 1, 4'b0000, "R5 old base gone");

    // R8 / R9: memory base, still disabled
    cfg_write(10'h02C, 16'h5123);
    cfg_write(10'h02E, 16'hFFFC);
    bus_fixed(20'hC5000, 1, 1, 0, 1, 0, 4'b0000, "R9 disabled");
    cfg_write(10'h116, 16'h0400);

    // R6 / R8: enabled memory window at 0xC5000
    bus_fixed(20'hC5000, 1, 1, 0, 1, 0, 4'b0010, "R6 mem read");
    bus_fixed(20'hC5FFF, 1, 1, 1, 0, 0, 4'b0001, "R6 low 12 bits ignored");
    bus_fixed(20'hC5000, 1, 1, 0, 1, 1, 4'b0000, "R6 cs high blocks");
    bus_fixed(20'hC6000, 1, 1, 0, 1, 0, 4'b0000, "R6 next page misses");
    bus_fixed(20'hD5000, 1, 1, 0, 1, 0, 4'b0000, "R8 high nibble is C");
    bus_fixed(20'hC5000, 1, 1, 0, 0, 0, 4'b0000, "R7 both mem strobes");
    bus(20'h35000, 1, 1, 0, 1, 0, "R8 model check");

    // R10: both windows live together
    cfg_write(10'h020, 16'h5230);
    bus_fixed(20'hC5230, 0, 1, 1, 0, 0, 4'b1001, "R10 io read + mem write");
    bus_fixed(20'h05230, 1, 0, 1, 1, 0, 4'b0100, "R10 io live while enabled");

    // R9: bus-control write with bit 10 clear, others set
    cfg_write(10'h116, 16'hFBFF);
    bus_fixed(20'hC5000, 1, 1, 0, 1, 0, 4'b0000, "R9 bit 10 clear disables");
    cfg_write(10'h116, 16'h0400);
    bus(20'hC5400, 1, 1, 1, 0, 0, "R9 re-enabled");

    @(posedge clk); #1;
    ior_n = 1; iow_n = 1; memr_n = 1; memw_n = 1;
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule